// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls the transfer of a complete SRAM image between the SRAM and a nonvolatile shadow array. A store copies the SRAM contents into the shadow array. A recall copies the shadow array back into the SRAM. The block does not sense supply voltage itself. Two digital comparator flags report the storage voltage instead: one says it is under the reset level, the other says it is over the switch level. The block sequences the copies from these flags. While a copy is in progress it drives a busy output, and the SRAM interface is locked out for that whole time.

A two-bit strap selects one of three power arrangements:

- Capacitor-backed automatic store. A falling switch flag launches a store and cuts the external supply.
- System-supply automatic store. The switch flag launches a store in the same way, but the supply connection is left alone.
- Automatic store inhibited. Only a rising edge on the hardware store pin launches a store.

Whenever the voltage is low, including at reset, a recall request is held. It is released when the voltage comes back. The strap is fixed for the whole time the block runs. Store and restore durations are parameters given in clock cycles.

Top module: `nv_store_recall_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `store_active`, `recall_active` and `op_done` are 0 and `ext_supply_en` is 1.
- R2: A recall request is held from reset onward and again in any cycle in which `v_below_reset` is 1. A held request starts a recall only in a cycle where the block is idle, `v_above_switch` is 1 and `v_below_reset` is 0.
- R3: A recall keeps `recall_active` and `busy` at 1 for exactly RESTORE_CYC clock cycles.
- R4: With `cfg_mode` 0 or 1 (automatic store), a 1-to-0 change of `v_above_switch` while idle starts a store. The store keeps `store_active` and `busy` at 1 for exactly STORE_CYC cycles.
- R5: With `cfg_mode` 0 (capacitor-backed), `ext_supply_en` goes to 0 when an automatic store starts. It stays 0 until the block is idle and `v_above_switch` is 1 again. With any other `cfg_mode`, `ext_supply_en` stays 1.
- R6: With `cfg_mode` 2 or 3 (store inhibited), a fall of `v_above_switch` starts nothing. A 0-to-1 change of `hw_store_req` while idle starts a store of STORE_CYC cycles.
- R7: With `cfg_mode` 0 or 1, `hw_store_req` has no effect.
- R8: A rising edge of `hw_store_req` that occurs during a store or a recall is dropped. It is not queued for later.
- R9: `op_done` pulses for one cycle, in the first cycle after each store or recall ends, when `busy` is already 0.
- R10: `store_active` and `recall_active` are never 1 together, and `busy` is 1 exactly when one of them is.
- R11: If a recall can start in the same cycle that a pin store request arrives, the recall wins and the pin request is discarded.
- R12: If `v_below_reset` rises during a store, the store still runs its full length. A recall follows once the voltage has recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Power arrangement strap: 0 capacitor-backed auto store, 1 system-supply auto store, 2 or 3 auto store inhibited |
| v_below_reset | input | 1 | Storage voltage is under the reset level |
| v_above_switch | input | 1 | Storage voltage is over the switch level |
| hw_store_req | input | 1 | Hardware store pin; a rising edge requests a store when auto store is inhibited |
| busy | output | 1 | A store or recall is running; the SRAM interface is locked out |
| store_active | output | 1 | A store is running |
| recall_active | output | 1 | A recall is running |
| ext_supply_en | output | 1 | External supply is connected to the storage node |
| op_done | output | 1 | One-cycle pulse after a store or recall ends |

## Verification
A table of vectors applies each strap setting to both launch sources: a fall of the switch flag and a pulse on the store pin. This separates the automatic modes from the inhibited mode and separates the capacitor-backed supply cut from the system-supply case. Every vector starts with a power-up recall, so the recall length and the held-request release are checked many times.

Directed cases then cover the remaining ordering questions. One brings a pin edge in the middle of a store, which shows whether the block drops it or queues it. One applies a low-power dip during a store, which shows whether the store is cut short. One makes a pin request arrive together with the release of a recall, which shows which of the two wins.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STORE  = 2'd1,
    ST_RECALL = 2'd2
  } nvs_state_t;

  // Strap 0 and 1 launch stores from the supply flag; 2 and 3 use the pin.
  function automatic logic auto_store_on(input logic [1:0] mode);
    return (mode < 2'd2);
  endfunction

  // Only strap 0 disconnects the external supply when a store starts.
  function automatic logic cap_backed(input logic [1:0] mode);
    return (mode == 2'd0);
  endfunction

  // Counter width able to hold n-1.
  function automatic int unsigned ctr_width(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nvs_edge.sv
module nvs_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic hit
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = d & ~d_q;
    end else begin : g_fall
      assign hit = ~d & d_q;
    end
  endgenerate
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvs_recall_latch.sv
module nvs_recall_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic low_power,
  input  logic grant,
  output logic pending
);
  // Reset counts as a low-power event: the request is held out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b1;
    else if (low_power) pending <= 1'b1;
    else if (grant)     pending <= 1'b0;
  end
endmodule

// File: rtl/nv_store_recall_seq.sv
module nv_store_recall_seq
  import nvs_pkg::*;
#(
  parameter int unsigned STORE_CYC   = 1000000,
  parameter int unsigned RESTORE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       v_below_reset,
  input  logic       v_above_switch,
  input  logic       hw_store_req,
  output logic       busy,
  output logic       store_active,
  output logic       recall_active,
  output logic       ext_supply_en,
  output logic       op_done
);
  localparam int unsigned MAX_CYC = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int unsigned CW      = ctr_width(MAX_CYC);
  localparam logic [CW-1:0] STORE_LD   = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RESTORE_LD = CW'(RESTORE_CYC - 1);

  nvs_state_t state_q, state_d;
  logic       fall_hit, pin_hit, recall_pend, t_expired;
  logic       idle, recall_go, auto_go, pin_go, store_go, op_end;
  logic       t_load, disc_q, done_q;
  logic [CW-1:0] t_val;

  nvs_edge #(.RISING(1'b0)) u_switch_fall (
    .clk(clk), .rst_n(rst_n), .d(v_above_switch), .hit(fall_hit)
  );

  nvs_edge #(.RISING(1'b1)) u_pin_rise (
    .clk(clk), .rst_n(rst_n), .d(hw_store_req), .hit(pin_hit)
  );

  nvs_recall_latch u_recall (
    .clk(clk), .rst_n(rst_n), .low_power(v_below_reset),
    .grant(recall_go), .pending(recall_pend)
  );

  nvs_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .expired(t_expired)
  );

  // Named launch events, visible to the checker.
  assign idle      = (state_q == ST_IDLE);
  assign recall_go = idle && recall_pend && v_above_switch && !v_below_reset;
  assign auto_go   = idle && auto_store_on(cfg_mode) && fall_hit;
  assign pin_go    = idle && !auto_store_on(cfg_mode) && pin_hit;
  assign store_go  = !recall_go && (auto_go || pin_go);
  assign op_end    = !idle && t_expired;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = STORE_LD;
    unique case (state_q)
      ST_IDLE: begin
        if (recall_go) begin
          state_d = ST_RECALL;
          t_load  = 1'b1;
          t_val   = RESTORE_LD;
        end else if (store_go) begin
          state_d = ST_STORE;
          t_load  = 1'b1;
          t_val   = STORE_LD;
        end
      end
      ST_STORE, ST_RECALL: begin
        if (t_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      disc_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= op_end;
      if (store_go && auto_go && cap_backed(cfg_mode)) disc_q <= 1'b1;
      else if (idle && v_above_switch)                  disc_q <= 1'b0;
    end
  end

  assign busy          = !idle;
  assign store_active  = (state_q == ST_STORE);
  assign recall_active = (state_q == ST_RECALL);
  assign ext_supply_en = !disc_q;
  assign op_done       = done_q;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
  parameter int unsigned STORE_CYC   = 1000000,
  parameter int unsigned RESTORE_CYC = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       v_below_reset,
  input logic       v_above_switch,
  input logic       hw_store_req,
  input logic       busy,
  input logic       store_active,
  input logic       recall_active,
  input logic       ext_supply_en,
  input logic       op_done
);
  int unsigned run_cnt;

  // Length of the current busy run, counted independently of the design timer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_active && recall_active));

  p_busy_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (store_active || recall_active));

  p_recall_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_active) |-> ($past(v_above_switch) && !$past(v_below_reset)));

  p_recall_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && $past(recall_active)) |-> (run_cnt == RESTORE_CYC));

  p_store_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && $past(store_active)) |-> (run_cnt == STORE_CYC));

  p_auto_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode < 2'd2 && $rose(store_active)) |-> !$past(v_above_switch));

  p_inh_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode >= 2'd2 && $rose(store_active)) |-> $past(hw_store_req));

  p_supply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd0) |-> ext_supply_en);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (!busy && $past(busy)));
endmodule

bind nv_store_recall_seq nvs_checker #(
  .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .v_below_reset(v_below_reset), .v_above_switch(v_above_switch),
  .hw_store_req(hw_store_req), .busy(busy), .store_active(store_active),
  .recall_active(recall_active), .ext_supply_en(ext_supply_en),
  .op_done(op_done)
);

// File: tb/nv_store_recall_seq_tb.sv
module nv_store_recall_seq_tb_top;
  localparam int ST = 12;
  localparam int RC = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       v_below_reset = 1'b1;
  logic       v_above_switch = 1'b0;
  logic       hw_store_req = 1'b0;
  logic       busy, store_active, recall_active, ext_supply_en, op_done;

  int checks = 0;
  int fails  = 0;
  int excl_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nv_store_recall_seq #(.STORE_CYC(ST), .RESTORE_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .v_below_reset(v_below_reset), .v_above_switch(v_above_switch),
    .hw_store_req(hw_store_req), .busy(busy), .store_active(store_active),
    .recall_active(recall_active), .ext_supply_en(ext_supply_en),
    .op_done(op_done)
  );

  // Vector fields: {mode[1:0], action (0 switch fall, 1 pin pulse), store expected, supply after}
  localparam logic [4:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Counts consecutive samples with busy high; kind bit0 = store seen, bit1 = recall seen.
  task automatic measure(output int len, output int kind);
    len = 0;
    kind = 0;
    while (busy && len < 200) begin
      if (store_active)  kind |= 1;
      if (recall_active) kind |= 2;
      if ((store_active && recall_active) || (busy != (store_active || recall_active)))
        excl_err++;
      len++;
      tick();
    end
  endtask

  task automatic power_up(input logic [1:0] mode);
    int len, kind;
    rst_n = 1'b0;
    cfg_mode = mode;
    v_below_reset = 1'b1;
    v_above_switch = 1'b0;
    hw_store_req = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    v_below_reset = 1'b0;
    tick();
    tick();
    chk("R2 no recall below switch", busy, 0);
    v_above_switch = 1'b1;
    tick();
    measure(len, kind);
    chk("R3 recall length", len, RC);
    chk("R3 recall kind", kind, 2);
    chk("R9 done after recall", op_done, 1);
    tick();
    chk("R9 done single pulse", op_done, 0);
  endtask

  initial begin
    int len, kind;
    // R1: reset state
    repeat (2) tick();
    chk("R1 busy in reset", busy, 0);
    chk("R1 supply in reset", ext_supply_en, 1);
    chk("R1 done in reset", op_done, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 busy after release", busy, 0);
    chk("R1 supply after release", ext_supply_en, 1);

    // Vector walk: R4, R5, R6, R7
    foreach (VEC[i]) begin
      power_up(VEC[i][4:3]);
      chk("R5 supply before launch", ext_supply_en, 1);
      if (VEC[i][2] == 1'b0) begin
        v_above_switch = 1'b0;
        tick();
      end else begin
        hw_store_req = 1'b1;
        tick();
        hw_store_req = 1'b0;
      end
      measure(len, kind);
      chk(VEC[i][2] ? "R6/R7 pin store length" : "R4/R6 fall store length",
          len, VEC[i][1] ? ST : 0);
      chk("R4/R6/R7 store kind", kind, VEC[i][1] ? 1 : 0);
      if (VEC[i][1]) chk("R9 done after store", op_done, 1);
      chk("R5 supply after launch", ext_supply_en, VEC[i][0]);
      v_above_switch = 1'b1;
      tick();
      tick();
      chk("R5 supply after recovery", ext_supply_en, 1);
      chk("R7 nothing started after", busy, 0);
    end

    // R8: pin edge during store is dropped, not queued
    power_up(2'd2);
    hw_store_req = 1'b1;
    tick();
    hw_store_req = 1'b0;
    len = 0;
    while (busy && len < 200) begin
      len++;
      hw_store_req = (len == 3);
      tick();
    end
    hw_store_req = 1'b0;
    chk("R8 store length with mid pin", len, ST);
    repeat (3) tick();
    chk("R8 no queued store", busy, 0);

    // R12: low-power dip during store
    power_up(2'd0);
    v_above_switch = 1'b0;
    tick();
    len = 0;
    kind = 0;
    while (busy && len < 200) begin
      if (store_active) kind |= 1;
      if (recall_active) kind |= 2;
      len++;
      v_below_reset = (len >= 4 && len < 7);
      tick();
    end
    v_below_reset = 1'b0;
    chk("R12 store not cut", len, ST);
    chk("R12 store kind", kind, 1);
    tick();
    chk("R12 no recall while low", busy, 0);
    v_above_switch = 1'b1;
    tick();
    measure(len, kind);
    chk("R12 recall after recovery", len, RC);
    chk("R12 recall kind", kind, 2);

    // R11: recall beats a simultaneous pin request
    rst_n = 1'b0;
    cfg_mode = 2'd3;
    v_below_reset = 1'b1;
    v_above_switch = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    v_below_reset = 1'b0;
    tick();
    v_above_switch = 1'b1;
    hw_store_req = 1'b1;
    tick();
    hw_store_req = 1'b0;
    measure(len, kind);
    chk("R11 recall wins length", len, RC);
    chk("R11 recall wins kind", kind, 2);
    repeat (3) tick();
    chk("R11 pin request discarded", busy, 0);

    chk("R10 exclusive activity", excl_err, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule